// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave side of a small serial memory on a two-wire bus. It samples the clock and data lines on a fast system clock and detects start and stop conditions. After a start it takes a single byte. The upper seven bits of that byte are a word address into a 128-byte array. The lowest bit chooses the direction. It answers on the data line only by pulling it low through an output-enable, so the bus stays open-drain.

Writes do not go straight into the array. Bytes are collected in a four-entry page buffer, and only the two low address bits step between bytes, so a long burst folds back onto the same page. The stop that ends a write starts a timed programming cycle. At the end of that cycle every buffered byte is copied into the array. While the cycle runs, the slave ignores the bus completely. Reads stream bytes from the array and advance the full address after each byte the master acknowledges.

Top module: `twowire_mem_slave`

## Requirements
- R1: After reset `sda_oe` and `busy` are 0 and every array location reads back as 0xFF.
- R2: Before the first start condition since reset, the slave never drives SDA, whatever SCL and SDA do.
- R3: After a start, the slave acknowledges the next byte by driving SDA low through the ninth SCL clock. That byte is sent MSB first, bits 7..1 are the word address, and bit 0 is the direction (0 = write, 1 = read).
- R4: In a write, every 8-bit data byte is acknowledged on its ninth clock.
- R5: A stop after at least one write data byte raises `busy` for exactly `PROG_CYCLES` system clocks. After that the written bytes read back from their addresses.
- R6: Within a write, only address bits 1..0 advance after each byte, and bits 6..2 stay fixed. A fifth or later byte therefore overwrites an earlier byte of the same page.
- R7: While `busy` is high the slave drives nothing, so the address byte is not acknowledged.
- R8: In a read, after each byte the master acknowledges, the full 7-bit address advances by one. It crosses page boundaries and goes from 127 to 0.
- R9: When the master does not acknowledge a read byte, the slave releases SDA and drives nothing until a stop or start.
- R10: A write that is stopped before any data byte starts no programming cycle.
- R11: A start in the middle of a write aborts it. The buffered bytes are discarded, no programming cycle follows, and the slave takes a fresh address byte.
- R12: `sda_oe` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pin |
| sda_i | input | 1 | Bus data line as seen at the pin |
| sda_oe | output | 1 | 1 pulls SDA low; 0 releases it |
| busy | output | 1 | High during the internal programming cycle |

## Verification
The bench writes a burst of six bytes starting mid-page and reads the page back. A design that carried into the upper address bits would leave the neighbouring page altered and the first two slots unchanged. A read that starts at address 127 must return address 0 next, which catches a counter stuck inside the page or one that saturates. The bench sends an address byte during programming and expects no acknowledge, and it measures the exact length of `busy`. It also restarts in the middle of a write and then reads the old contents. A design that committed the aborted page, or that programmed after an empty write, would show new data or a raised `busy`. Bytes clocked after a master NACK must read as all ones, which exposes a slave that keeps transmitting.

// File: rtl/twowire_mem_slave.sv
`timescale 1ns/1ps
module twowire_mem_slave #(
  parameter int PROG_CYCLES = 200,
  parameter int PAGE_W      = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic scl_i,
  input  logic sda_i,
  output logic sda_oe,
  output logic busy
);
  localparam int AW    = 7;
  localparam int DEPTH = 1 << AW;
  localparam int PAGE  = 1 << PAGE_W;
  localparam int CW    = $clog2(PROG_CYCLES + 1);

  typedef enum logic [2:0] {
    ST_IDLE, ST_ADDR, ST_AACK, ST_WR, ST_WACK, ST_RD, ST_RACK, ST_HOLD
  } state_t;

  logic [2:0]        scl_p, sda_p;
  state_t            st;
  logic [7:0]        mem  [DEPTH];
  logic [7:0]        page [PAGE];
  logic [PAGE-1:0]   pvld;
  logic [AW-1:0]     addr;
  logic              rw;
  logic [7:0]        sh;
  logic [3:0]        cnt;
  logic              mack;
  logic [CW-1:0]     pcnt;

  wire scl_rise  = scl_p[1] & ~scl_p[2];
  wire scl_fall  = ~scl_p[1] & scl_p[2];
  wire bus_start = scl_p[1] & scl_p[2] & sda_p[2] & ~sda_p[1];
  wire bus_stop  = scl_p[1] & scl_p[2] & ~sda_p[2] & sda_p[1];
  wire sda_s     = sda_p[1];

  wire [7:0]    rd_byte = mem[addr];
  wire [AW-1:0] addr_nx = addr + 1'b1;
  wire [7:0]    nx_byte = mem[addr_nx];
  wire          wr_open = (st == ST_WR) || (st == ST_WACK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_p <= 3'b111;
      sda_p <= 3'b111;
    end else begin
      scl_p <= {scl_p[1:0], scl_i};
      sda_p <= {sda_p[1:0], sda_i};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      busy   <= 1'b0;
      pvld   <= '0;
      addr   <= '0;
      rw     <= 1'b0;
      sh     <= '0;
      cnt    <= '0;
      mack   <= 1'b0;
      pcnt   <= '0;
      for (int i = 0; i < DEPTH; i++) mem[i] <= 8'hFF;
      for (int i = 0; i < PAGE; i++)  page[i] <= 8'h00;
    end else if (busy) begin
      if (pcnt == '0) begin
        busy <= 1'b0;
        pvld <= '0;
        for (int i = 0; i < PAGE; i++)
          if (pvld[i]) mem[{addr[AW-1:PAGE_W], PAGE_W'(i)}] <= page[i];
      end else begin
        pcnt <= pcnt - 1'b1;
      end
    end else if (bus_start) begin
      st     <= ST_ADDR;
      cnt    <= '0;
      sda_oe <= 1'b0;
      pvld   <= '0;
    end else if (bus_stop) begin
      st     <= ST_IDLE;
      sda_oe <= 1'b0;
      if (wr_open && |pvld) begin
        busy <= 1'b1;
        pcnt <= CW'(PROG_CYCLES - 1);
      end
    end else begin
      case (st)
        ST_ADDR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            addr   <= sh[7:1];
            rw     <= sh[0];
            sda_oe <= 1'b1;
            st     <= ST_AACK;
          end
        end
        ST_AACK: begin
          if (scl_fall) begin
            cnt <= '0;
            if (rw) begin
              st     <= ST_RD;
              sda_oe <= ~rd_byte[7];
            end else begin
              st     <= ST_WR;
              sda_oe <= 1'b0;
            end
          end
        end
        ST_WR: begin
          if (scl_rise) begin
            sh  <= {sh[6:0], sda_s};
            cnt <= cnt + 1'b1;
          end else if (scl_fall && cnt == 4'd8) begin
            page[addr[PAGE_W-1:0]] <= sh;
            pvld[addr[PAGE_W-1:0]] <= 1'b1;
            addr[PAGE_W-1:0]       <= addr[PAGE_W-1:0] + 1'b1;
            sda_oe                 <= 1'b1;
            st                     <= ST_WACK;
          end
        end
        ST_WACK: begin
          if (scl_fall) begin
            sda_oe <= 1'b0;
            cnt    <= '0;
            st     <= ST_WR;
          end
        end
        ST_RD: begin
          if (scl_rise) begin
            cnt <= cnt + 1'b1;
          end else if (scl_fall) begin
            if (cnt == 4'd8) begin
              sda_oe <= 1'b0;
              st     <= ST_RACK;
            end else begin
              sda_oe <= ~rd_byte[3'd7 - cnt[2:0]];
            end
          end
        end
        ST_RACK: begin
          if (scl_rise) begin
            mack <= ~sda_s;
          end else if (scl_fall) begin
            cnt <= '0;
            if (mack) begin
              addr   <= addr_nx;
              sda_oe <= ~nx_byte[7];
              st     <= ST_RD;
            end else begin
              st <= ST_HOLD;
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/twowire_mem_slave_chk.sv
`timescale 1ns/1ps
module twowire_mem_slave_chk #(
  parameter int PROG_CYCLES = 200
) (
  input logic clk,
  input logic rst_n,
  input logic scl_i,
  input logic sda_i,
  input logic sda_oe,
  input logic busy
);
  logic scl_d, sda_d, seen_start;
  int   run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_d      <= 1'b1;
      sda_d      <= 1'b1;
      seen_start <= 1'b0;
      run_len    <= 0;
    end else begin
      scl_d <= scl_i;
      sda_d <= sda_i;
      if (scl_i && scl_d && sda_d && !sda_i) seen_start <= 1'b1;
      run_len <= busy ? run_len + 1 : 0;
    end
  end

  // R12
  oe_scl_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(sda_oe) |-> !scl_i);

  // R7
  busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !sda_oe);

  // R5
  prog_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> run_len == PROG_CYCLES);

  // R2
  no_drive_before_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sda_oe |-> seen_start);
endmodule

bind twowire_mem_slave twowire_mem_slave_chk #(.PROG_CYCLES(PROG_CYCLES)) chk_i (
  .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
  .sda_oe(sda_oe), .busy(busy)
);

// File: tb/twowire_mem_slave_tb.sv
`timescale 1ns/1ps
module twowire_mem_slave_tb_top;
  localparam int PROG = 600;
  localparam int QT   = 160;

  logic clk = 1'b0, rst_n = 1'b0, scl_m = 1'b1, sda_m = 1'b1;
  logic sda_oe, busy;
  wire  sda_line = sda_m & ~sda_oe;

  twowire_mem_slave #(.PROG_CYCLES(PROG)) dut_i (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line),
    .sda_oe(sda_oe), .busy(busy)
  );

  always #10 clk = ~clk;

  typedef struct { string req; int val; } exp_t;
  exp_t exp_q[$];
  int   act_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  task automatic expect_v(string req, int v); exp_q.push_back('{req, v}); endtask
  task automatic observe(int v); act_q.push_back(v); endtask

  initial begin : monitor
    exp_t e;
    int   a;
    forever begin
      @(negedge clk);
      while (act_q.size() > 0 && exp_q.size() > 0) begin
        e = exp_q.pop_front();
        a = act_q.pop_front();
        n_chk++;
        if (a != e.val) begin
          n_bad++;
          $display("FAIL %s: actual=0x%0h expected=0x%0h", e.req, a, e.val);
        end
      end
    end
  end

  int busy_run = 0, last_len = 0, oe_bad = 0;
  logic oe_prev = 1'b0;
  always @(posedge clk) begin
    if (busy) busy_run <= busy_run + 1;
    else begin
      if (busy_run != 0) last_len <= busy_run;
      busy_run <= 0;
    end
    oe_prev <= sda_oe;
    if (rst_n && sda_oe !== oe_prev && scl_m) oe_bad <= oe_bad + 1;
  end

  task automatic bus_start();
    sda_m = 1'b1; #(QT); scl_m = 1'b1; #(QT); sda_m = 1'b0; #(QT); scl_m = 1'b0; #(QT);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; #(QT); scl_m = 1'b1; #(QT); sda_m = 1'b1; #(2*QT);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) begin
      sda_m = b[i]; #(QT); scl_m = 1'b1; #(2*QT); scl_m = 1'b0; #(QT);
    end
    sda_m = 1'b1; #(QT); scl_m = 1'b1; #(QT); ack = ~sda_line; #(QT); scl_m = 1'b0; #(QT);
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    sda_m = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      #(QT); scl_m = 1'b1; #(QT); b[i] = sda_line; #(QT); scl_m = 1'b0;
    end
    #(QT); sda_m = ~give_ack; #(QT); scl_m = 1'b1; #(2*QT); scl_m = 1'b0; #(QT); sda_m = 1'b1;
  endtask

  logic [7:0] wdat [8];
  logic [7:0] rexp [8];

  task automatic write_seq(input logic [6:0] a, input int n);
    logic ack;
    bus_start();
    send_byte({a, 1'b0}, ack); expect_v("R3 write address ack", 1); observe(ack);
    for (int i = 0; i < n; i++) begin
      send_byte(wdat[i], ack); expect_v("R4 data ack", 1); observe(ack);
    end
    bus_stop();
  endtask

  task automatic read_seq(input logic [6:0] a, input int n, input string req);
    logic ack;
    logic [7:0] b;
    bus_start();
    send_byte({a, 1'b1}, ack); expect_v("R3 read address ack", 1); observe(ack);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b); expect_v(req, rexp[i]); observe(b);
    end
    bus_stop();
  endtask

  task automatic wait_prog();
    expect_v("R5 busy after stop", 1); observe(busy);
    wait (busy == 1'b0);
    repeat (4) @(negedge clk);
    expect_v("R5 busy length", PROG); observe(last_len);
  endtask

  initial begin : main
    logic ack;
    logic [7:0] b;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    expect_v("R1 oe after reset", 0); observe(sda_oe);
    expect_v("R1 busy after reset", 0); observe(busy);

    // R2: a full byte with no start before it
    scl_m = 1'b0; #(QT);
    send_byte(8'h20, ack); expect_v("R2 no ack before start", 0); observe(ack);

    // R1: erased contents
    rexp[0] = 8'hFF; rexp[1] = 8'hFF;
    read_seq(7'h10, 2, "R1 erased read");

    // R4/R5: four-byte page write
    wdat[0] = 8'hA1; wdat[1] = 8'hB2; wdat[2] = 8'hC3; wdat[3] = 8'hD4;
    write_seq(7'h10, 4);
    expect_v("R5 busy after stop", 1); observe(busy);
    // R7: address byte during programming
    bus_start();
    send_byte({7'h10, 1'b1}, ack); expect_v("R7 no ack while busy", 0); observe(ack);
    bus_stop();
    wait (busy == 1'b0);
    repeat (4) @(negedge clk);
    expect_v("R5 busy length", PROG); observe(last_len);
    rexp[0] = 8'hA1; rexp[1] = 8'hB2; rexp[2] = 8'hC3; rexp[3] = 8'hD4;
    read_seq(7'h10, 4, "R5 read back page");

    // R6: six bytes from 0x21 wrap inside page 0x20..0x23
    for (int i = 0; i < 6; i++) wdat[i] = 8'(i + 1);
    write_seq(7'h21, 6);
    wait_prog();
    rexp[0] = 8'hFF; rexp[1] = 8'h04; rexp[2] = 8'h05; rexp[3] = 8'h06;
    rexp[4] = 8'h03; rexp[5] = 8'hFF;
    read_seq(7'h1F, 6, "R6 page wrap / R8 cross page");

    // R8: address 127 rolls to 0
    wdat[0] = 8'h77; write_seq(7'h7F, 1); wait_prog();
    wdat[0] = 8'h5A; write_seq(7'h00, 1); wait_prog();
    rexp[0] = 8'h77; rexp[1] = 8'h5A;
    read_seq(7'h7F, 2, "R8 address rollover");

    // R9: after NACK the slave stays off the line
    bus_start();
    send_byte({7'h10, 1'b1}, ack); expect_v("R3 read address ack", 1); observe(ack);
    recv_byte(1'b0, b); expect_v("R9 first byte", 8'hA1); observe(b);
    recv_byte(1'b0, b); expect_v("R9 released after nack", 8'hFF); observe(b);
    bus_stop();

    // R10: empty write
    bus_start();
    send_byte({7'h30, 1'b0}, ack); expect_v("R3 write address ack", 1); observe(ack);
    bus_stop();
    repeat (20) @(negedge clk);
    expect_v("R10 no programming", 0); observe(busy);

    // R11: restart in the middle of a write
    bus_start();
    send_byte({7'h10, 1'b0}, ack); expect_v("R3 write address ack", 1); observe(ack);
    send_byte(8'h55, ack); expect_v("R4 data ack", 1); observe(ack);
    send_byte(8'h66, ack); expect_v("R4 data ack", 1); observe(ack);
    bus_start();
    send_byte({7'h10, 1'b1}, ack); expect_v("R11 new address ack", 1); observe(ack);
    recv_byte(1'b0, b); expect_v("R11 old data kept", 8'hA1); observe(b);
    bus_stop();
    repeat (20) @(negedge clk);
    expect_v("R11 no programming", 0); observe(busy);

    expect_v("R12 oe steady while SCL high", 0); observe(oe_bad);
    repeat (5) @(negedge clk);
    done = 1;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin : watchdog
    #(64'd20 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule